// File: doc/BRIEF.md
# Double-Buffered DMA Channel Register Set

This block holds the programming of one camera-receiver DMA write channel. It has two copies of every setting. Software writes into a pending copy: the buffer length, the line stride, the destination address (split into a low word and an upper part), the frame size and a control word. The DMA engine sees only a separate active copy. All values that describe memory are in 16-byte units, so software shifts its byte values right by four before writing them.

A write to the low address word is the commit. It moves the whole pending copy into the active copy at once, which means the low address word must always be written last. The commit takes effect at once when the channel is between frames. It also takes effect at once when it lands on a frame-start or frame-end strobe, or when the committed control word carries the force bit. A force-only control word committed in this way stops the channel in the middle of a frame.

A commit that arrives during a frame without force is held back and is promoted at the next frame-start strobe. A loaded buffer is used up at frame end unless auto-arm is set, in which case the same active set is used again for every following frame.

Top module: `dbr_dma_chan_regs`

## Requirements
- R1: After reset, all active outputs are zero, `ch_en` is low, and every shadow register reads back as zero.
- R2: A write to any register other than the low address word (index 4) leaves every active output unchanged.
- R3: `rd_data` shows the pending shadow value selected by `rd_idx`, zero-extended to the stored width. The indices are: 0 control, 1 length, 2 stride, 3 address high, 4 address low, 5 frame size. Indices 6 and 7 read as zero.
- R4: A write to index 4 while no frame is in progress copies every shadow register, together with the written low word, into the active set on the same clock edge.
- R5: A write to index 4 during a frame, without force, leaves the active set unchanged. The set it commits becomes active on the next `frame_start`.
- R6: When the committed control word has the force bit (bit 3) set, the commit takes effect at once, even mid-frame. A force-only word, with bit 0 clear, drops `ch_en`.
- R7: `ch_en` is high only when the active control word has the enable bit (bit 0) set and a buffer is armed. A commit arms a buffer. A `frame_end` without auto-arm disarms it, so a later `frame_start` with nothing pending keeps `ch_en` low.
- R8: With auto-arm (bit 4) active, `frame_end` does not disarm, and the active buffer is reused on each following frame.
- R9: The control word decodes as: bit 0 enable, bits 2:1 mode, bit 3 force, bit 4 auto-arm, bits 6:5 virtual channel, bits 12:7 data type.
- R10: The frame-size register holds the height in bits 31:16 and the width in bits 15:0. When the active frame size is zero, `act_mode` is 0 whatever the control word holds.
- R11: `act_addr` is the address-high register (truncated to its stored width) placed above the 32-bit low word.
- R12: A commit on the same cycle as `frame_end` or `frame_start` is promoted at once and arms the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Register index for the write |
| wr_data | input | 32 | Write data |
| rd_idx | input | 3 | Register index for read-back |
| rd_data | output | 32 | Pending shadow value at `rd_idx` |
| frame_start | input | 1 | Frame-start strobe |
| frame_end | input | 1 | Frame-end strobe |
| ch_en | output | 1 | Channel enabled and armed |
| act_mode | output | 2 | Active channel mode |
| act_vchan | output | 2 | Active virtual channel |
| act_dtype | output | 6 | Active data type |
| act_auto_arm | output | 1 | Active auto-arm setting |
| act_len | output | LEN_W | Active buffer length, 16-byte units |
| act_stride | output | STRIDE_W | Active line stride, 16-byte units |
| act_addr | output | BYTE_ADDR_W-4 | Active destination address, 16-byte units |
| act_width | output | 16 | Active frame width |
| act_height | output | 16 | Active frame height |

## Verification
The commit path is exercised in four situations: between frames, during a frame without force, during a frame with a force-only control word, and on the same cycle as a frame strobe. These separate an immediate copy from a deferred promotion, and they show whether force bypasses the deferral. Sequences of frame strobes with and without auto-arm, and with nothing pending, show whether arming is consumed at frame end or kept. Writes to every register except the low address word, including a lone address-high write during a frame, show that no field leaks into the active set before the commit. Full-width writes show the truncation and zero-extension on read-back.

// File: rtl/dbr_regs_pkg.sv
`timescale 1ns/1ps
package dbr_regs_pkg;

   typedef enum logic [2:0] {
      IDX_CTRL    = 3'd0,
      IDX_LEN     = 3'd1,
      IDX_STRIDE  = 3'd2,
      IDX_ADDR_HI = 3'd3,
      IDX_ADDR_LO = 3'd4,
      IDX_FSIZE   = 3'd5
   } reg_idx_e;

   localparam int CTRL_W = 13;

   // Field order is the bit order software writes (MSB first).
   typedef struct packed {
      logic [5:0] dtype;
      logic [1:0] vchan;
      logic       auto_arm;
      logic       force_off;
      logic [1:0] mode;
      logic       dma_en;
   } ctrl_t;

endpackage

// File: rtl/dbr_shadow_file.sv
`timescale 1ns/1ps
module dbr_shadow_file
   import dbr_regs_pkg::*;
#(
   parameter int LEN_W    = 28,
   parameter int STRIDE_W = 20,
   parameter int HI_W     = 12,
   localparam int SET_W   = 32 + CTRL_W + LEN_W + STRIDE_W + HI_W + 32
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_idx,
   input  logic [31:0]      wr_data,
   input  logic [2:0]       rd_idx,
   output logic [31:0]      rd_data,
   output logic             commit,
   output logic [SET_W-1:0] snap
);

   logic [CTRL_W-1:0]   ctrl_q;
   logic [LEN_W-1:0]    len_q;
   logic [STRIDE_W-1:0] stride_q;
   logic [HI_W-1:0]     hi_q;
   logic [31:0]         lo_q;
   logic [31:0]         fsize_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         len_q    <= '0;
         stride_q <= '0;
         hi_q     <= '0;
         lo_q     <= '0;
         fsize_q  <= '0;
      end else if (wr_en) begin
         case (reg_idx_e'(wr_idx))
            IDX_CTRL:    ctrl_q   <= wr_data[CTRL_W-1:0];
            IDX_LEN:     len_q    <= wr_data[LEN_W-1:0];
            IDX_STRIDE:  stride_q <= wr_data[STRIDE_W-1:0];
            IDX_ADDR_HI: hi_q     <= wr_data[HI_W-1:0];
            IDX_ADDR_LO: lo_q     <= wr_data;
            IDX_FSIZE:   fsize_q  <= wr_data;
            default: ;
         endcase
      end
   end

   assign commit = wr_en && (wr_idx == IDX_ADDR_LO);

   // The low word comes straight from the bus so the commit sees it this cycle.
   assign snap = {fsize_q, ctrl_q, len_q, stride_q, hi_q, wr_data};

   always_comb begin
      case (reg_idx_e'(rd_idx))
         IDX_CTRL:    rd_data = 32'(ctrl_q);
         IDX_LEN:     rd_data = 32'(len_q);
         IDX_STRIDE:  rd_data = 32'(stride_q);
         IDX_ADDR_HI: rd_data = 32'(hi_q);
         IDX_ADDR_LO: rd_data = lo_q;
         IDX_FSIZE:   rd_data = fsize_q;
         default:     rd_data = '0;
      endcase
   end

   // R2: only the low address word may raise the commit
   assert_only_lo_commits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx != IDX_ADDR_LO) |-> !commit);

   // R3: a length write is visible on read-back one cycle later
   assert_len_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_LEN && rd_idx == IDX_LEN) |=>
         (rd_data == 32'($past(wr_data[LEN_W-1:0]))));

endmodule

// File: rtl/dbr_commit_seq.sv
`timescale 1ns/1ps
module dbr_commit_seq #(
   parameter int SET_W = 141
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit,
   input  logic [SET_W-1:0] snap,
   input  logic             snap_force,
   input  logic             frame_start,
   input  logic             frame_end,
   input  logic             act_auto,
   output logic [SET_W-1:0] act_set,
   output logic             armed
);

   logic             in_frame;
   logic             pend;
   logic [SET_W-1:0] staged;
   logic             take_now;

   // A commit goes through at once unless a frame is running and no strobe or force applies.
   assign take_now = commit && (!in_frame || frame_start || frame_end || snap_force);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame <= 1'b0;
         pend     <= 1'b0;
         staged   <= '0;
         act_set  <= '0;
         armed    <= 1'b0;
      end else begin
         if (frame_start)    in_frame <= 1'b1;
         else if (frame_end) in_frame <= 1'b0;

         if (take_now) begin
            act_set <= snap;
            armed   <= 1'b1;
            pend    <= 1'b0;
         end else if (commit) begin
            staged <= snap;
            pend   <= 1'b1;
         end else if (frame_start && pend) begin
            act_set <= staged;
            armed   <= 1'b1;
            pend    <= 1'b0;
         end else if (frame_end && !act_auto) begin
            armed <= 1'b0;
         end
      end
   end

   assert_idle_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !in_frame) |=> (act_set == $past(snap)));

   assert_mid_frame_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && in_frame && !frame_start && !frame_end && !snap_force) |=> $stable(act_set));

   assert_force_now_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && snap_force) |=> (act_set == $past(snap)));

   assert_disarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && !frame_start && !commit && !act_auto) |=> !armed);

   assert_keep_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && armed && act_auto) |=> armed);

   assert_strobe_commit_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && (frame_start || frame_end)) |=> (armed && act_set == $past(snap)));

endmodule

// File: rtl/dbr_dma_chan_regs.sv
`timescale 1ns/1ps
module dbr_dma_chan_regs
   import dbr_regs_pkg::*;
#(
   parameter int BYTE_ADDR_W     = 48,
   parameter int UNIT_SHIFT      = 4,
   parameter int LEN_W           = 28,
   parameter int STRIDE_W        = 20,
   parameter bit ZERO_SIZE_MODE0 = 1'b1,
   localparam int ADDR_W         = BYTE_ADDR_W - UNIT_SHIFT
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [2:0]          wr_idx,
   input  logic [31:0]         wr_data,
   input  logic [2:0]          rd_idx,
   output logic [31:0]         rd_data,
   input  logic                frame_start,
   input  logic                frame_end,
   output logic                ch_en,
   output logic [1:0]          act_mode,
   output logic [1:0]          act_vchan,
   output logic [5:0]          act_dtype,
   output logic                act_auto_arm,
   output logic [LEN_W-1:0]    act_len,
   output logic [STRIDE_W-1:0] act_stride,
   output logic [ADDR_W-1:0]   act_addr,
   output logic [15:0]         act_width,
   output logic [15:0]         act_height
);

   localparam int HI_W     = ADDR_W - 32;
   localparam int OFF_HI   = 32;
   localparam int OFF_STR  = OFF_HI + HI_W;
   localparam int OFF_LEN  = OFF_STR + STRIDE_W;
   localparam int OFF_CTRL = OFF_LEN + LEN_W;
   localparam int OFF_FSZ  = OFF_CTRL + CTRL_W;
   localparam int SET_W    = OFF_FSZ + 32;

   if (HI_W < 1 || HI_W > 32) begin : g_bad_addr
      $error("address width must leave 1..32 bits for the high word");
   end
   if (LEN_W < 1 || LEN_W > 32 || STRIDE_W < 1 || STRIDE_W > 32) begin : g_bad_len
      $error("length and stride widths must be 1..32");
   end

   logic             commit;
   logic [SET_W-1:0] snap;
   logic [SET_W-1:0] act_set;
   logic             armed;
   ctrl_t            snap_ctrl;
   ctrl_t            act_ctrl;
   logic [31:0]      act_fsize;
   logic             unused_force;

   dbr_shadow_file #(
      .LEN_W(LEN_W), .STRIDE_W(STRIDE_W), .HI_W(HI_W)
   ) u_shadow (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(rd_data),
      .commit(commit), .snap(snap)
   );

   assign snap_ctrl = ctrl_t'(snap[OFF_CTRL +: CTRL_W]);
   assign act_ctrl  = ctrl_t'(act_set[OFF_CTRL +: CTRL_W]);

   dbr_commit_seq #(.SET_W(SET_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .commit(commit), .snap(snap), .snap_force(snap_ctrl.force_off),
      .frame_start(frame_start), .frame_end(frame_end),
      .act_auto(act_ctrl.auto_arm),
      .act_set(act_set), .armed(armed)
   );

   assign act_fsize    = act_set[OFF_FSZ +: 32];
   assign act_len      = act_set[OFF_LEN +: LEN_W];
   assign act_stride   = act_set[OFF_STR +: STRIDE_W];
   assign act_addr     = {act_set[OFF_HI +: HI_W], act_set[31:0]};
   assign act_width    = act_fsize[15:0];
   assign act_height   = act_fsize[31:16];
   assign act_vchan    = act_ctrl.vchan;
   assign act_dtype    = act_ctrl.dtype;
   assign act_auto_arm = act_ctrl.auto_arm;
   assign ch_en        = act_ctrl.dma_en && armed;
   assign unused_force = act_ctrl.force_off;

   if (ZERO_SIZE_MODE0) begin : g_mode_gated
      assign act_mode = (act_fsize == '0) ? 2'd0 : act_ctrl.mode;
   end else begin : g_mode_plain
      assign act_mode = act_ctrl.mode;
   end

   assert_enable_needs_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && !frame_start && !commit && !act_auto_arm) |=> !ch_en);

   assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx != IDX_ADDR_LO && !frame_start) |=> $stable(act_addr));

endmodule

// File: tb/dbr_dma_chan_regs_tb.sv
`timescale 1ns/1ps
module dbr_dma_chan_regs_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_idx = '0;
   logic [31:0] rd_data;
   logic        frame_start = 1'b0;
   logic        frame_end = 1'b0;
   logic        ch_en;
   logic [1:0]  act_mode;
   logic [1:0]  act_vchan;
   logic [5:0]  act_dtype;
   logic        act_auto_arm;
   logic [27:0] act_len;
   logic [19:0] act_stride;
   logic [43:0] act_addr;
   logic [15:0] act_width;
   logic [15:0] act_height;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dbr_dma_chan_regs u_dut (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(rd_data),
      .frame_start(frame_start), .frame_end(frame_end),
      .ch_en(ch_en), .act_mode(act_mode), .act_vchan(act_vchan),
      .act_dtype(act_dtype), .act_auto_arm(act_auto_arm),
      .act_len(act_len), .act_stride(act_stride), .act_addr(act_addr),
      .act_width(act_width), .act_height(act_height)
   );

   typedef struct packed {
      logic        we;
      logic [2:0]  idx;
      logic [31:0] dat;
      logic        fs;
      logic        fe;
      logic [31:0] exp_len;
      logic        exp_en;
      logic [3:0]  req;
   } vec_t;

   localparam int NVEC = 20;
   localparam vec_t VEC [NVEC] = '{
      '{1'b1, 3'd1, 32'h10,  1'b0, 1'b0, 32'h00, 1'b0, 4'd2}, // R2 length shadow only
      '{1'b1, 3'd0, 32'h01,  1'b0, 1'b0, 32'h00, 1'b0, 4'd2}, // R2 control shadow only
      '{1'b1, 3'd4, 32'h100, 1'b0, 1'b0, 32'h10, 1'b1, 4'd4}, // R4 idle commit
      '{1'b0, 3'd0, 32'h0,   1'b1, 1'b0, 32'h10, 1'b1, 4'd7}, // R7 frame begins
      '{1'b1, 3'd1, 32'h20,  1'b0, 1'b0, 32'h10, 1'b1, 4'd2}, // R2 mid-frame length
      '{1'b1, 3'd4, 32'h200, 1'b0, 1'b0, 32'h10, 1'b1, 4'd5}, // R5 held pending
      '{1'b0, 3'd0, 32'h0,   1'b0, 1'b1, 32'h10, 1'b0, 4'd7}, // R7 buffer used up
      '{1'b0, 3'd0, 32'h0,   1'b1, 1'b0, 32'h20, 1'b1, 4'd5}, // R5 promoted at start
      '{1'b0, 3'd0, 32'h0,   1'b0, 1'b1, 32'h20, 1'b0, 4'd7}, // R7 disarm
      '{1'b0, 3'd0, 32'h0,   1'b1, 1'b0, 32'h20, 1'b0, 4'd7}, // R7 nothing pending
      '{1'b0, 3'd0, 32'h0,   1'b0, 1'b1, 32'h20, 1'b0, 4'd7},
      '{1'b1, 3'd0, 32'h11,  1'b0, 1'b0, 32'h20, 1'b0, 4'd2}, // R2 auto-arm staged
      '{1'b1, 3'd4, 32'h300, 1'b0, 1'b0, 32'h20, 1'b1, 4'd8}, // R8 commit with auto
      '{1'b0, 3'd0, 32'h0,   1'b1, 1'b0, 32'h20, 1'b1, 4'd8},
      '{1'b0, 3'd0, 32'h0,   1'b0, 1'b1, 32'h20, 1'b1, 4'd8}, // R8 stays armed
      '{1'b0, 3'd0, 32'h0,   1'b1, 1'b0, 32'h20, 1'b1, 4'd8}, // R8 reused
      '{1'b1, 3'd0, 32'h08,  1'b0, 1'b0, 32'h20, 1'b1, 4'd6}, // R6 force-only staged
      '{1'b1, 3'd1, 32'h40,  1'b0, 1'b0, 32'h20, 1'b1, 4'd6},
      '{1'b1, 3'd4, 32'h0,   1'b0, 1'b0, 32'h40, 1'b0, 4'd6}, // R6 forced stop mid-frame
      '{1'b0, 3'd0, 32'h0,   1'b0, 1'b1, 32'h40, 1'b0, 4'd6}
   };

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic step(input logic we, input logic [2:0] idx, input logic [31:0] dat,
                       input logic fs, input logic fe);
      @(negedge clk);
      wr_en = we; wr_idx = idx; wr_data = dat; frame_start = fs; frame_end = fe;
      @(negedge clk);
      wr_en = 1'b0; frame_start = 1'b0; frame_end = 1'b0;
   endtask

   task automatic readback(input logic [2:0] idx, input logic [31:0] exp, input string tag);
      rd_idx = idx;
      #0.5;
      check(tag, 64'(rd_data), 64'(exp));
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 ch_en", 64'(ch_en), 64'd0);
      check("R1 act_len", 64'(act_len), 64'd0);
      check("R1 act_addr", 64'(act_addr), 64'd0);
      for (int i = 0; i < 6; i++) readback(3'(i), 32'd0, "R1 shadow");

      // table walk: R2 R4 R5 R6 R7 R8
      for (int v = 0; v < NVEC; v++) begin
         step(VEC[v].we, VEC[v].idx, VEC[v].dat, VEC[v].fs, VEC[v].fe);
         n_chk++;
         if (act_len !== VEC[v].exp_len[27:0] || ch_en !== VEC[v].exp_en) begin
            n_bad++;
            $display("FAIL R%0d row %0d: got len=0x%0h en=%0b expected len=0x%0h en=%0b",
                     VEC[v].req, v, act_len, ch_en, VEC[v].exp_len, VEC[v].exp_en);
         end
      end

      // R3 read-back of pending values, truncation and zero-extension; R2 no leak
      step(1'b1, 3'd1, 32'h0ABCDEF1, 1'b0, 1'b0);
      step(1'b1, 3'd2, 32'hFFFFFFFF, 1'b0, 1'b0);
      step(1'b1, 3'd3, 32'hFFFFF123, 1'b0, 1'b0);
      step(1'b1, 3'd0, 32'hFFFFFFFF, 1'b0, 1'b0);
      step(1'b1, 3'd5, 32'h00300040, 1'b0, 1'b0);
      readback(3'd1, 32'h0ABCDEF1, "R3 length");
      readback(3'd2, 32'h000FFFFF, "R3 stride");
      readback(3'd3, 32'h00000123, "R3 addr high");
      readback(3'd0, 32'h00001FFF, "R3 control");
      readback(3'd5, 32'h00300040, "R3 frame size");
      readback(3'd6, 32'h0, "R3 unused index");
      check("R2 act_len after shadow writes", 64'(act_len), 64'h40);
      check("R2 act_addr after shadow writes", 64'(act_addr), 64'h0);

      // R9 R10 R11 R4: full commit between frames
      step(1'b1, 3'd0, 32'h00001565, 1'b0, 1'b0);
      step(1'b1, 3'd4, 32'h89ABCDEF, 1'b0, 1'b0);
      check("R11 act_addr", 64'(act_addr), 64'h123_89ABCDEF);
      check("R4 act_len", 64'(act_len), 64'h0ABCDEF1);
      check("R4 act_stride", 64'(act_stride), 64'hFFFFF);
      check("R9 mode", 64'(act_mode), 64'd2);
      check("R9 vchan", 64'(act_vchan), 64'd3);
      check("R9 dtype", 64'(act_dtype), 64'h2A);
      check("R9 auto", 64'(act_auto_arm), 64'd0);
      check("R9 enable", 64'(ch_en), 64'd1);
      check("R10 width", 64'(act_width), 64'h40);
      check("R10 height", 64'(act_height), 64'h30);
      readback(3'd4, 32'h89ABCDEF, "R3 addr low");

      // R10 zero frame size forces mode 0
      step(1'b1, 3'd5, 32'h0, 1'b0, 1'b0);
      step(1'b1, 3'd4, 32'h1, 1'b0, 1'b0);
      check("R10 zero-size mode", 64'(act_mode), 64'd0);
      check("R10 zero width", 64'(act_width), 64'd0);

      // R12 commit on the frame-end cycle
      step(1'b0, 3'd0, 32'h0, 1'b1, 1'b0);
      step(1'b1, 3'd1, 32'h55, 1'b0, 1'b0);
      check("R5 mid-frame length held", 64'(act_len), 64'h0ABCDEF1);
      step(1'b1, 3'd4, 32'h2, 1'b0, 1'b1);
      check("R12 fe commit length", 64'(act_len), 64'h55);
      check("R12 fe commit armed", 64'(ch_en), 64'd1);

      // R12 commit on the frame-start cycle during a running frame
      step(1'b0, 3'd0, 32'h0, 1'b1, 1'b0);
      step(1'b1, 3'd1, 32'h66, 1'b0, 1'b0);
      step(1'b1, 3'd4, 32'h3, 1'b1, 1'b0);
      check("R12 fs commit length", 64'(act_len), 64'h66);

      // R2 lone address-high write mid-frame never reaches the active set
      step(1'b1, 3'd3, 32'h7, 1'b0, 1'b0);
      step(1'b0, 3'd0, 32'h0, 1'b0, 1'b1);
      check("R7 disarmed at end", 64'(ch_en), 64'd0);
      step(1'b0, 3'd0, 32'h0, 1'b1, 1'b0);
      check("R2 addr high unchanged", 64'(act_addr[43:32]), 64'h123);
      readback(3'd3, 32'h7, "R3 pending addr high");

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule